// File: doc/BRIEF.md
# Serial Bit-Clock Generator

This block produces the bit timing for one serial channel. The channel runs either as an asynchronous UART or as a clock-synchronous link. The system clock first passes through a prescaler with a selectable ratio. A reloadable rate counter then divides it by n+1, where n is an 8-bit rate value. A post-divider follows, and its ratio depends on the operating mode. The block delivers one-cycle enable strobes, one for the transmit shifter and one for the receive shifter. It also drives a serial clock output whose polarity can be inverted.

In clock-synchronous mode the channel can instead take its clock from an external pin. The pin is first brought into the system clock domain by a synchronizer. Its edges are then detected and turned into the same transmit and receive strobes. The shift registers, framing and flow control live in a neighbouring block, which consumes these strobes.

Top module: `serclk_gen`

## Requirements
- R1: The source select picks the prescale ratio P: 00 gives the base clock, 01 gives base/8, and 10 and 11 both give base/32. The base clock is the system clock when `src_half`=0 and the system clock divided by 2 when `src_half`=1.
- R2: The rate counter divides the prescaled clock by `rate_div`+1, so rate_div=0 divides by 1 and rate_div=255 divides by 256.
- R3: Mode values 100, 101 and 110 select UART timing. In UART timing `tx_stb` and `rx_stb` pulse in the same cycle, once every 16*(rate_div+1)*P system clocks.
- R4: Mode values 001 and 010 with `ext_dir`=0 select internal clock-synchronous timing. The internal clock changes level every (rate_div+1)*P clocks. `tx_stb` marks each falling edge and `rx_stb` marks each rising edge, so each strobe repeats every 2*(rate_div+1)*P clocks and the two strobes never pulse together.
- R5: Mode values 000, 011 and 111 produce no strobes. In these modes the serial clock stays at its idle level, which is high before the polarity is applied.
- R6: `clk_pol`=1 inverts `sclk_out`. In the idle state `sclk_out` is therefore 0 instead of 1. On a transmit strobe it is 1 instead of 0.
- R7: In clock-synchronous mode with `ext_dir`=1, the effective level is `sclk_in` XOR `clk_pol`. Each rising edge of that level gives exactly one `rx_stb` and each falling edge gives exactly one `tx_stb`, within 4 clocks of the pin change.
- R8: In UART timing `ext_dir` has no effect, and the strobe period is that of R3.
- R9: A new `rate_div` value takes effect only when the counter reaches its terminal count. The interval already running finishes with the old value.
- R10: No strobe is ever high for two cycles in a row while the mode is held.
- R11: During and after reset both strobes are low and `sclk_out` is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating mode code (R3, R4, R5) |
| src_sel | input | 2 | Prescaler select |
| src_half | input | 1 | Halve the base clock |
| rate_div | input | 8 | Rate value n, divide by n+1 |
| ext_dir | input | 1 | 1 = external clock pin in synchronous mode |
| clk_pol | input | 1 | Serial clock polarity inversion |
| sclk_in | input | 1 | External serial clock pin |
| tx_stb | output | 1 | Transmit bit enable, one cycle |
| rx_stb | output | 1 | Receive bit enable, one cycle |
| sclk_out | output | 1 | Serial clock output |

## Verification
The hardest behaviour to reach from the ports is a rate change landing in the middle of a running interval. The bench must observe that the interval in flight is not cut short. To do this it runs internal synchronous mode with a 1:1 prescale, waits for an edge of `sclk_out`, and writes a new rate value at that moment. It then measures the next edges, which must be 4 clocks apart for the old value and 10 clocks apart for the new one. The external-clock path is exercised by toggling the pin while the block is running. The polarity is changed only while the mode is off, so that the polarity change does not itself create an edge.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    typedef enum logic [1:0] {
        TM_OFF      = 2'd0,
        TM_UART     = 2'd1,
        TM_SYNC_INT = 2'd2,
        TM_SYNC_EXT = 2'd3
    } timing_e;

    function automatic timing_e decode_timing(input logic [2:0] mode, input logic ext_dir);
        timing_e t;
        case (mode)
            3'b100, 3'b101, 3'b110: t = TM_UART;
            3'b001, 3'b010:         t = ext_dir ? TM_SYNC_EXT : TM_SYNC_INT;
            default:                t = TM_OFF;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/serclk_rate.sv
module serclk_rate #(
    parameter int DIV_W    = 8,
    parameter int MED_DIV  = 8,
    parameter int SLOW_DIV = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       src_sel,
    input  logic             src_half,
    input  logic [DIV_W-1:0] rate_div,
    output logic             rate_tick
);
    localparam int PRE_W = $clog2(2 * SLOW_DIV);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] rate;
    } rate_st_t;

    rate_st_t st_d, st_q;
    logic [PRE_W:0]   base;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;
    logic             src_tick;

    always_comb begin
        case (src_sel)
            2'b00:   base = (PRE_W+1)'(1);
            2'b01:   base = (PRE_W+1)'(MED_DIV);
            default: base = (PRE_W+1)'(SLOW_DIV);
        endcase
        span      = src_half ? (base << 1) : base;
        limit     = PRE_W'(span - 1'b1);
        src_tick  = run && (st_q.pre >= limit);
        rate_tick = src_tick && (st_q.rate == '0);

        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (src_tick) begin
            st_d.pre  = '0;
            st_d.rate = (st_q.rate == '0) ? rate_div : st_q.rate - 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/serclk_post.sv
module serclk_post #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uart_en,
    input  logic sync_en,
    input  logic rate_tick,
    output logic phase,
    output logic tx_stb,
    output logic rx_stb
);
    localparam int OVS_W = $clog2(OVS);

    typedef struct packed {
        logic [OVS_W-1:0] ovs;
        logic             phase;
        logic             tx;
        logic             rx;
    } post_st_t;

    post_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.tx = 1'b0;
        st_d.rx = 1'b0;
        if (uart_en) begin
            st_d.phase = 1'b1;
            if (rate_tick) begin
                if (st_q.ovs == OVS_W'(OVS - 1)) begin
                    st_d.ovs = '0;
                    st_d.tx  = 1'b1;
                    st_d.rx  = 1'b1;
                end else begin
                    st_d.ovs = st_q.ovs + 1'b1;
                end
            end
        end else if (sync_en) begin
            st_d.ovs = '0;
            if (rate_tick) begin
                st_d.phase = ~st_q.phase;
                st_d.tx    = st_q.phase;
                st_d.rx    = ~st_q.phase;
            end
        end else begin
            st_d.ovs   = '0;
            st_d.phase = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ovs: '0, phase: 1'b1, tx: 1'b0, rx: 1'b0};
        else        st_q <= st_d;
    end

    assign phase  = st_q.phase;
    assign tx_stb = st_q.tx;
    assign rx_stb = st_q.rx;
endmodule

// File: rtl/serclk_edge.sv
module serclk_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin_in,
    input  logic pol,
    output logic tx_stb,
    output logic rx_stb
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              last;
        logic              tx;
        logic              rx;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     level, rise, fall;

    always_comb begin
        level   = st_q.sync[SYNC_N-1];
        rise    = level & ~st_q.last;
        fall    = ~level & st_q.last;
        st_d    = st_q;
        st_d.sync[0] = pin_in ^ pol;
        for (int i = 1; i < SYNC_N; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.last = level;
        st_d.tx   = en & fall;
        st_d.rx   = en & rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sync: '1, last: 1'b1, tx: 1'b0, rx: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_stb = st_q.tx;
    assign rx_stb = st_q.rx;
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int MED_DIV  = 8,
    parameter int SLOW_DIV = 32,
    parameter int OVS      = 16,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic [1:0]       src_sel,
    input  logic             src_half,
    input  logic [DIV_W-1:0] rate_div,
    input  logic             ext_dir,
    input  logic             clk_pol,
    input  logic             sclk_in,
    output logic             tx_stb,
    output logic             rx_stb,
    output logic             sclk_out
);
    timing_e tm;
    logic    run_uart, run_int, run_ext;
    logic    rate_tick;
    logic    int_phase, int_tx, int_rx;
    logic    ext_tx, ext_rx;

    always_comb begin
        tm       = decode_timing(mode, ext_dir);
        run_uart = (tm == TM_UART);
        run_int  = (tm == TM_SYNC_INT);
        run_ext  = (tm == TM_SYNC_EXT);
    end

    serclk_rate #(
        .DIV_W   (DIV_W),
        .MED_DIV (MED_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_uart | run_int),
        .src_sel  (src_sel),
        .src_half (src_half),
        .rate_div (rate_div),
        .rate_tick(rate_tick)
    );

    serclk_post #(.OVS(OVS)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .uart_en  (run_uart),
        .sync_en  (run_int),
        .rate_tick(rate_tick),
        .phase    (int_phase),
        .tx_stb   (int_tx),
        .rx_stb   (int_rx)
    );

    serclk_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_ext),
        .pin_in(sclk_in),
        .pol   (clk_pol),
        .tx_stb(ext_tx),
        .rx_stb(ext_rx)
    );

    assign tx_stb   = int_tx | ext_tx;
    assign rx_stb   = int_rx | ext_rx;
    assign sclk_out = int_phase ^ clk_pol;
endmodule

// File: rtl/serclk_gen_chk.sv
module serclk_gen_chk
    import serclk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       ext_dir,
    input logic       clk_pol,
    input logic       tx_stb,
    input logic       rx_stb,
    input logic       sclk_out
);
    timing_e tm;
    assign tm = decode_timing(mode, ext_dir);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tm == TM_OFF && $past(tm) == TM_OFF) |-> (!tx_stb && !rx_stb)); // R5

    AST_UART_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (tm == TM_UART && $past(tm) == TM_UART) |-> (tx_stb == rx_stb)); // R3

    AST_SYNC_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (tm inside {TM_SYNC_INT, TM_SYNC_EXT} && $past(tm) == tm) |-> !(tx_stb && rx_stb)); // R4

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (tm != TM_SYNC_INT && $past(tm) != TM_SYNC_INT) |-> (sclk_out == !clk_pol)); // R6

    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stb && $stable(mode)) |=> (!tx_stb || !$stable(mode))); // R10

    AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && $stable(mode)) |=> (!rx_stb || !$stable(mode))); // R10
endmodule

bind serclk_gen serclk_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .ext_dir (ext_dir),
    .clk_pol (clk_pol),
    .tx_stb  (tx_stb),
    .rx_stb  (rx_stb),
    .sclk_out(sclk_out)
);

// File: tb/sim_serclk_gen.sv
`timescale 1ns/1ps
module sim_serclk_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode;
    logic [1:0] src_sel;
    logic       src_half;
    logic [7:0] rate_div;
    logic       ext_dir;
    logic       clk_pol;
    logic       sclk_in;
    logic       tx_stb, rx_stb, sclk_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    serclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .src_sel(src_sel), .src_half(src_half),
        .rate_div(rate_div), .ext_dir(ext_dir), .clk_pol(clk_pol), .sclk_in(sclk_in),
        .tx_stb(tx_stb), .rx_stb(rx_stb), .sclk_out(sclk_out)
    );

    // fields: mode[30:28] sel[27:26] half[25] ext[24] n[23:16] period[15:0]
    localparam int NV = 9;
    localparam logic [30:0] VEC [NV] = '{
        {3'b100, 2'b00, 1'b0, 1'b0, 8'd0,   16'd16},
        {3'b101, 2'b00, 1'b1, 1'b0, 8'd2,   16'd96},
        {3'b110, 2'b01, 1'b0, 1'b0, 8'd1,   16'd256},
        {3'b100, 2'b00, 1'b0, 1'b1, 8'd1,   16'd32},
        {3'b001, 2'b00, 1'b0, 1'b0, 8'd4,   16'd10},
        {3'b010, 2'b10, 1'b0, 1'b0, 8'd0,   16'd64},
        {3'b001, 2'b11, 1'b0, 1'b0, 8'd0,   16'd64},
        {3'b001, 2'b00, 1'b0, 1'b0, 8'd255, 16'd512},
        {3'b010, 2'b01, 1'b1, 1'b0, 8'd3,   16'd128}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe(input bit want_rx, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_rx ? rx_stb : tx_stb) && n < 20000);
    endtask

    task automatic wait_edge(output int n);
        logic prev;
        prev = sclk_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sclk_out == prev && n < 20000);
    endtask

    task automatic pin_step(input logic lvl, output int ntx, output int nrx);
        sclk_in = lvl;
        ntx = 0;
        nrx = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            ntx += int'(tx_stb);
            nrx += int'(rx_stb);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int a, b, ntx, nrx, cnt;
        logic [30:0] v;
        rst_n = 1'b0; mode = 3'b000; src_sel = 2'b00; src_half = 1'b0;
        rate_div = 8'd0; ext_dir = 1'b0; clk_pol = 1'b0; sclk_in = 1'b0;

        repeat (3) @(negedge clk);
        check(!tx_stb && !rx_stb && sclk_out, "R11 reset outputs", {tx_stb, rx_stb, sclk_out}, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!tx_stb && !rx_stb && sclk_out, "R11 after reset", {tx_stb, rx_stb, sclk_out}, 1);

        // table: R1 R2 R3 R4 R8 periods
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            mode = 3'b000;
            repeat (2) @(negedge clk);
            src_sel = v[27:26]; src_half = v[25]; ext_dir = v[24]; rate_div = v[23:16];
            mode = v[30:28];
            wait_strobe(1'b0, a);
            wait_strobe(1'b0, b);
            check(b == int'(v[15:0]), $sformatf("R1/R2/R3/R4/R8 vec%0d tx period", i), b, int'(v[15:0]));
            if (v[30]) check(rx_stb == 1'b1, $sformatf("R3 vec%0d rx with tx", i), rx_stb, 1);
            else       check(sclk_out == 1'b0, $sformatf("R4 vec%0d sclk low at tx", i), sclk_out, 0);
            wait_strobe(1'b1, a);
            wait_strobe(1'b1, b);
            check(b == int'(v[15:0]), $sformatf("R2 vec%0d rx period", i), b, int'(v[15:0]));
            if (!v[30]) check(sclk_out == 1'b1, $sformatf("R4 vec%0d sclk high at rx", i), sclk_out, 1);
        end

        // R5 / R6: disabled codes, both polarities
        ext_dir = 1'b0; src_sel = 2'b00; src_half = 1'b0; rate_div = 8'd0;
        for (int p = 0; p < 2; p++) begin
            clk_pol = p[0];
            foreach (VEC[j]) begin end
            for (int m = 0; m < 3; m++) begin
                mode = (m == 0) ? 3'b000 : (m == 1) ? 3'b011 : 3'b111;
                cnt = 0;
                repeat (3) @(negedge clk);
                for (int k = 0; k < 100; k++) begin
                    @(negedge clk);
                    cnt += int'(tx_stb) + int'(rx_stb) + int'(sclk_out != !clk_pol);
                end
                check(cnt == 0, $sformatf("R5 mode %0d pol %0d quiet", mode, p), cnt, 0);
            end
            check(sclk_out == !clk_pol, "R6 idle level", sclk_out, int'(!clk_pol));
        end

        // R6: inverted internal clock
        clk_pol = 1'b1; rate_div = 8'd2; mode = 3'b001;
        wait_strobe(1'b0, a);
        wait_strobe(1'b0, b);
        check(b == 6, "R4 pol1 period", b, 6);
        check(sclk_out == 1'b1, "R6 sclk high at tx with pol1", sclk_out, 1);
        mode = 3'b000;
        repeat (3) @(negedge clk);

        // R7: external clock, polarity 0 then 1
        clk_pol = 1'b0; sclk_in = 1'b0; ext_dir = 1'b1;
        repeat (6) @(negedge clk);
        mode = 3'b001;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            pin_step(~sclk_in, ntx, nrx);
            check(nrx == int'(sclk_in) && ntx == int'(!sclk_in), $sformatf("R7 pol0 step%0d rx", k), nrx, int'(sclk_in));
        end
        mode = 3'b000;
        clk_pol = 1'b1;
        repeat (6) @(negedge clk);
        mode = 3'b010;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            pin_step(~sclk_in, ntx, nrx);
            check(ntx == int'(sclk_in) && nrx == int'(!sclk_in), $sformatf("R7 pol1 step%0d tx", k), ntx, int'(sclk_in));
        end
        mode = 3'b000;
        clk_pol = 1'b0; ext_dir = 1'b0;
        repeat (4) @(negedge clk);

        // R9: rate change mid-interval waits for terminal count
        rate_div = 8'd3; mode = 3'b001;
        wait_edge(a);
        rate_div = 8'd9;
        wait_edge(a);
        check(a == 4, "R9 running interval keeps old rate", a, 4);
        wait_edge(a);
        check(a == 10, "R9 new rate after terminal", a, 10);
        wait_edge(a);
        check(a == 10, "R9 new rate steady", a, 10);
        mode = 3'b000;
        repeat (3) @(negedge clk);

        // R10: strobes last one cycle at the fastest setting
        rate_div = 8'd0; mode = 3'b001; cnt = 0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            a = int'(tx_stb);
            @(negedge clk);
            cnt += a & int'(tx_stb);
        end
        check(cnt == 0, "R10 no back-to-back tx", cnt, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule